// File: doc/BRIEF.md
# Windowed Wide Instruction Store

This block keeps eight program words, each 257 bits wide, for a consuming engine. A 32-bit register window gives software access to them. One register, the select register, names an entry and a 32-bit slice of that entry. A second register, the data register, writes that slice or reads it back. A word is nine slices long. Slices 0 to 7 are full. Slice 8 carries only the top bit of the word.

The engine fetches words over a valid/ready request channel that takes a program-counter index. It gets the chosen word back over a valid/ready response channel. The response word is read live from the store: while a response is held, a software write to that entry appears on the response word one cycle later.

Back-pressure rules: a request is accepted in a cycle where `eng_req_valid` and `eng_req_ready` are both high. `eng_req_ready` is high when no response is pending, or when the pending response is being taken in the same cycle. While `eng_rsp_valid` is high and `eng_rsp_ready` is low, the response and its entry index stay held. The response word itself can change only through a software write to the held entry.

Top module: `instr_window_store`

## Requirements
- R1: After reset, the select register reads 0, `eng_rsp_valid` is 0, and every stored bit is 0.
- R2: Register address encoding: `reg_addr`=0 is the select register and `reg_addr`=1 is the data register. In the select register, bits [2:0] are the entry index and bits [6:3] are the slice position. A write to the select register stores bits [6:0]. Reading it returns those bits, and bits [31:7] read as 0.
- R3: A data write at position p from 0 to 7 replaces bits [32p+31:32p] of the selected entry. A data read at that position returns those bits.
- R4: At position 8, a data write stores only data bit 0, into word bit 256. A read at position 8 returns that bit in bit 0, and bits [31:1] read as 0.
- R5: At positions 9 to 15, a data write changes no stored bit, and a data read returns 0.
- R6: A register write takes effect at the clock edge that samples the strobe. A read in the next cycle returns the new value.
- R7: A request accepted at an edge makes `eng_rsp_valid` 1 in the next cycle, with `eng_rsp_word` equal to the entry named by `eng_req_pc`.
- R8: `eng_req_ready` = !`eng_rsp_valid` || `eng_rsp_ready`. While a response is stalled, `eng_rsp_valid` and the held entry index stay unchanged.
- R9: A data write to the entry held on the response port appears on `eng_rsp_word` in the next cycle.
- R10: When a response is taken and no request is accepted in the same cycle, `eng_rsp_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = select register, 1 = data register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| eng_req_valid | input | 1 | Engine fetch request valid |
| eng_req_ready | output | 1 | Fetch request can be accepted |
| eng_req_pc | input | 3 | Entry index to fetch |
| eng_rsp_valid | output | 1 | Fetched word is valid |
| eng_rsp_ready | input | 1 | Engine takes the word |
| eng_rsp_word | output | 257 | Full word of the held entry |

## Verification
A distinct pattern is written into every slice of every entry, with the entry and slice number encoded in the value. A slice landing in the wrong entry or at the wrong offset therefore shows up both at the window and on the engine word.

The boundary slice is driven with all ones and then with only bit 0 cleared. This separates correct single-bit storage from an unmasked 32-bit store. The out-of-range positions are written with all ones, and then the whole entry is fetched to prove it is untouched.

Engine traffic is tested in three patterns:
- back-to-back requests with the response always taken;
- a stall with a competing request that must not be accepted;
- a software write to the held entry during a stall, which must show up live.

// File: rtl/isw_pkg.sv
package isw_pkg;
  typedef enum logic {
    REG_SEL  = 1'b0,
    REG_DATA = 1'b1
  } isw_reg_e;

  function automatic int unsigned isw_ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/isw_select_reg.sv
module isw_select_reg #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned POS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W+POS_W-1:0] wr_val,
  output logic [IDX_W-1:0] idx_o,
  output logic [POS_W-1:0] pos_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_o <= '0;
      pos_o <= '0;
    end else if (wr_en) begin
      idx_o <= wr_val[IDX_W-1:0];
      pos_o <= wr_val[IDX_W+POS_W-1:IDX_W];
    end
  end
endmodule

// File: rtl/isw_slice_store.sv
module isw_slice_store #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned WORD_W  = 257,
  parameter int unsigned SLICE_W = 32,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned POS_W   = 4,
  parameter int unsigned SLICES  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   win_idx,
  input  logic [POS_W-1:0]   win_pos,
  input  logic [SLICE_W-1:0] wr_data,
  output logic [SLICE_W-1:0] win_rdata,
  input  logic [IDX_W-1:0]   eng_idx,
  output logic [WORD_W-1:0]  eng_word
);
  logic [WORD_W-1:0]  word_flat [ENTRIES];
  logic [SLICE_W-1:0] slice_pad [ENTRIES][SLICES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
      localparam int unsigned LO  = s * SLICE_W;
      localparam int unsigned TOP = (LO + SLICE_W > WORD_W) ? WORD_W : LO + SLICE_W;
      localparam int unsigned SW  = TOP - LO;
      logic [SW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (wr_en && win_idx == IDX_W'(e) && win_pos == POS_W'(s)) q <= wr_data[SW-1:0];
      end
      assign word_flat[e][TOP-1:LO] = q;
      assign slice_pad[e][s] = SLICE_W'(q);
    end
  end

  always_comb begin
    win_rdata = '0;
    if (32'(win_pos) < SLICES) win_rdata = slice_pad[win_idx][win_pos];
  end

  assign eng_word = word_flat[eng_idx];
endmodule

// File: rtl/isw_eng_port.sv
module isw_eng_port #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_idx,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [IDX_W-1:0] held_idx
);
  logic fire;
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      held_idx  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      held_idx  <= req_idx;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r7_fire_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && held_idx == $past(held_idx)));
  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);
endmodule

// File: rtl/instr_window_store.sv
module instr_window_store
  import isw_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned WORD_W  = 257,
  parameter int unsigned SLICE_W = 32,
  parameter int unsigned POS_W   = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [SLICE_W-1:0] reg_wdata,
  output logic [SLICE_W-1:0] reg_rdata,
  input  logic               eng_req_valid,
  output logic               eng_req_ready,
  input  logic [IDX_W-1:0]   eng_req_pc,
  output logic               eng_rsp_valid,
  input  logic               eng_rsp_ready,
  output logic [WORD_W-1:0]  eng_rsp_word
);
  localparam int unsigned SLICES      = isw_ceil_div(WORD_W, SLICE_W);
  localparam int unsigned FULL_SLICES = WORD_W / SLICE_W;
  localparam int unsigned SEL_W       = IDX_W + POS_W;

  logic [IDX_W-1:0]   sel_idx, held_idx;
  logic [POS_W-1:0]   sel_pos;
  logic [SLICE_W-1:0] win_rdata;
  logic               sel_we, data_we;

  assign sel_we  = reg_wr && (reg_addr == REG_SEL);
  assign data_we = reg_wr && (reg_addr == REG_DATA);

  isw_select_reg #(.IDX_W(IDX_W), .POS_W(POS_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(sel_we), .wr_val(reg_wdata[SEL_W-1:0]),
    .idx_o(sel_idx), .pos_o(sel_pos)
  );

  isw_slice_store #(
    .ENTRIES(ENTRIES), .WORD_W(WORD_W), .SLICE_W(SLICE_W),
    .IDX_W(IDX_W), .POS_W(POS_W), .SLICES(SLICES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(data_we), .win_idx(sel_idx), .win_pos(sel_pos),
    .wr_data(reg_wdata), .win_rdata(win_rdata), .eng_idx(held_idx), .eng_word(eng_rsp_word)
  );

  isw_eng_port #(.IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .req_valid(eng_req_valid), .req_ready(eng_req_ready),
    .req_idx(eng_req_pc), .rsp_valid(eng_rsp_valid), .rsp_ready(eng_rsp_ready),
    .held_idx(held_idx)
  );

  assign reg_rdata = (reg_addr == REG_SEL) ? SLICE_W'({sel_pos, sel_idx}) : win_rdata;

  a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && 32'(sel_pos) < FULL_SLICES) |=>
      (reg_addr == REG_SEL || reg_rdata == $past(reg_wdata)));
  a_r4_last_slice_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == REG_DATA && 32'(sel_pos) == FULL_SLICES) |-> (reg_rdata[SLICE_W-1:1] == '0));
  a_r5_high_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == REG_DATA && 32'(sel_pos) >= SLICES) |-> (reg_rdata == '0));
  a_r9_live_word: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && eng_rsp_valid && !eng_rsp_ready && sel_idx == held_idx &&
     32'(sel_pos) < FULL_SLICES) |=>
      (eng_rsp_word[int'(sel_pos)*SLICE_W +: SLICE_W] == $past(reg_wdata)));
endmodule

// File: tb/tb_instr_window_store.sv
`timescale 1ns/1ps
module tb_instr_window_store;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr, reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         eng_req_valid, eng_req_ready, eng_rsp_valid, eng_rsp_ready;
  logic [2:0]   eng_req_pc;
  logic [256:0] eng_rsp_word;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  instr_window_store dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_req_valid(eng_req_valid),
    .eng_req_ready(eng_req_ready), .eng_req_pc(eng_req_pc), .eng_rsp_valid(eng_rsp_valid),
    .eng_rsp_ready(eng_rsp_ready), .eng_rsp_word(eng_rsp_word)
  );

  // reference model
  logic [6:0]   m_sel;
  logic [256:0] m_mem [8];
  logic         m_rv;
  logic [2:0]   m_pc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel <= '0;
      m_rv  <= 1'b0;
      m_pc  <= '0;
      for (int i = 0; i < 8; i++) m_mem[i] <= '0;
    end else begin
      if (reg_wr && !reg_addr) m_sel <= reg_wdata[6:0];
      if (reg_wr && reg_addr) begin
        if (m_sel[6:3] < 8) m_mem[m_sel[2:0]][32*m_sel[6:3] +: 32] <= reg_wdata;
        else if (m_sel[6:3] == 8) m_mem[m_sel[2:0]][256] <= reg_wdata[0];
      end
      if (eng_req_valid && (!m_rv || eng_rsp_ready)) begin
        m_rv <= 1'b1;
        m_pc <= eng_req_pc;
      end else if (eng_rsp_ready) m_rv <= 1'b0;
    end
  end

  function automatic logic [31:0] m_rdata();
    if (!reg_addr) return {25'b0, m_sel};
    if (m_sel[6:3] < 8) return m_mem[m_sel[2:0]][32*m_sel[6:3] +: 32];
    if (m_sel[6:3] == 8) return {31'b0, m_mem[m_sel[2:0]][256]};
    return 32'b0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [256:0] act, input logic [256:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic addr, input logic [31:0] wd,
                     input logic qv, input logic [2:0] pc, input logic rr, input string tag);
    @(negedge clk);
    reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    eng_req_valid = qv; eng_req_pc = pc; eng_rsp_ready = rr;
    #1;
    chk(tag, "reg_rdata", 257'(reg_rdata), 257'(m_rdata()));
    chk(tag, "rsp_valid", 257'(eng_rsp_valid), 257'(m_rv));
    chk(tag, "req_ready", 257'(eng_req_ready), 257'(!m_rv || rr));
    if (m_rv) chk(tag, "rsp_word", eng_rsp_word, m_mem[m_pc]);
  endtask

  task automatic sel_wr(input logic [2:0] idx, input logic [3:0] pos, input string tag);
    cyc(1, 0, {25'b0, pos, idx}, 0, 0, 1, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    eng_req_valid = 0; eng_req_pc = 0; eng_rsp_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    cyc(0, 0, 0, 0, 0, 1, "R1");
    for (int p = 0; p < 9; p++) begin
      sel_wr(3'd7, 4'(p), "R1");
      cyc(0, 1, 0, 0, 0, 1, "R1");
    end
    cyc(0, 0, 0, 1, 3'd4, 1, "R1");
    cyc(0, 0, 0, 0, 0, 1, "R1");
    // R2: select register fields, upper bits ignored
    cyc(1, 0, 32'hFFFF_FF9D, 0, 0, 1, "R2");
    cyc(0, 0, 0, 0, 0, 1, "R2");
    cyc(1, 0, 32'h1234_5642, 0, 0, 1, "R2");
    cyc(0, 0, 0, 0, 0, 1, "R2");
    // R3 / R6: every full slice of every entry
    for (int e = 0; e < 8; e++) begin
      for (int p = 0; p < 8; p++) begin
        sel_wr(3'(e), 4'(p), "R3");
        cyc(1, 1, {8'(e), 8'(p), 16'hC35A} ^ (32'h9E37_79B9 * (e * 8 + p + 1)), 0, 0, 1, "R3");
        cyc(0, 1, 0, 0, 0, 1, "R6");
      end
    end
    // R4: single-bit last slice
    for (int k = 0; k < 2; k++) begin
      sel_wr(k == 0 ? 3'd0 : 3'd7, 4'd8, "R4");
      cyc(1, 1, 32'hFFFF_FFFF, 0, 0, 1, "R4");
      cyc(0, 1, 0, 0, 0, 1, "R4");
      cyc(1, 1, 32'hFFFF_FFFE, 0, 0, 1, "R4");
      cyc(0, 1, 0, 0, 0, 1, "R4");
      cyc(1, 1, 32'h0000_0001, 0, 0, 1, "R4");
      cyc(0, 1, 0, 1, k == 0 ? 3'd0 : 3'd7, 1, "R4");
      cyc(0, 1, 0, 0, 0, 1, "R4");
    end
    // R5: positions 9..15 ignored, read zero
    for (int p = 9; p < 16; p++) begin
      sel_wr(3'd3, 4'(p), "R5");
      cyc(1, 1, 32'hFFFF_FFFF, 0, 0, 1, "R5");
      cyc(0, 1, 0, 1, 3'd3, 1, "R5");
      cyc(0, 1, 0, 0, 0, 1, "R5");
    end
    // R7: back-to-back fetches
    for (int pc = 0; pc < 8; pc++) cyc(0, 0, 0, 1, 3'(7 - pc), 1, "R7");
    // R10: drain
    cyc(0, 0, 0, 0, 0, 1, "R10");
    cyc(0, 0, 0, 0, 0, 1, "R10");
    // R8: stall with competing request
    cyc(0, 0, 0, 1, 3'd2, 1, "R8");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 3'd6, 0, "R8");
    // R9: live write to held entry during stall
    cyc(1, 0, {25'b0, 4'd4, 3'd2}, 0, 0, 0, "R9");
    cyc(1, 1, 32'hDEAD_BEEF, 0, 0, 0, "R9");
    cyc(0, 1, 0, 0, 0, 0, "R9");
    cyc(1, 1, 32'h0BAD_F00D, 0, 0, 0, "R9");
    cyc(0, 1, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 1, 3'd6, 1, "R8");
    cyc(0, 0, 0, 0, 0, 1, "R10");
    cyc(0, 0, 0, 0, 0, 1, "R10");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule